// File: doc/BRIEF.md
# Three-Channel Segmented Video DAC Cell Driver

This block is the digital control path of a three-lane (red, green, blue) current-steering video converter. Each lane runs on its own clock. On that clock it captures a 10-bit unsigned sample and a blanking flag. It then turns the captured sample into cell-select vectors for a segmented current array. The six high-order bits become a thermometer code that enables 63 equal cells, each worth 16 LSB. The four low-order bits drive four binary-weighted cells directly.

For every lane the block drives a true select vector and a complementary select vector. While a lane is driving, the complementary vector is the bitwise inverse of the true vector, so the two current paths together always carry full scale. A lane goes mute when its synchronous blanking flag is high or the shared sleep input is high. Both vectors are then all zero and no cell steers current. Sleep acts at once, without waiting for any clock edge.

Each lane is a small state machine with two states. LANE_MUTE is the zero-output state and is also the reset state. LANE_DRIVE steers the decoded code. On every edge of its clock the lane moves from either state to LANE_MUTE if the blanking flag it captured one cycle earlier is high, and to LANE_DRIVE if that flag is low.

Top module: `dac_front`

## Requirements
- R1: The thermometer select of a lane has exactly as many ones as the value of code bits [9:4]. Bit i of the thermometer is set if and only if that value is greater than i, so the ones fill upward from bit 0.
- R2: The binary select of a driving lane equals code bits [3:0], and bit j of it has weight 2^j LSB.
- R3: For a driving lane, 16 × (number of thermometer ones) + binary select equals the captured code. Code 1023 sets all 63 thermometer bits and binary 15. Code 512 sets 32 thermometer bits and binary 0. Code 0 sets no true select.
- R4: A code and blanking flag applied to a lane appear at that lane's selects after exactly two edges of that lane's own clock. Edges of the other lanes' clocks do not change it.
- R5: While a lane drives, its complementary thermometer and binary selects are the bitwise inverse of its true selects. True and complementary selects never overlap.
- R6: A blanking flag of 1 mutes the lane, with all four select vectors at zero, after the same two-edge latency. A flag of 0 brings normal output back after the same latency.
- R7: While sleep is 1, all select vectors of all lanes are zero with no clock edge needed. When sleep returns to 0, each lane shows its registered selects again.
- R8: An active-low reset clears all lanes to the mute state at once. After reset is released, a lane stays mute until it has seen two edges of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Asynchronous shutdown; 1 forces every select to zero |
| ch_clk | input | 3 | Per-lane clock; bit 0 red, 1 green, 2 blue |
| ch_code | input | 30 | Per-lane 10-bit code; lane c at bits [10c+9:10c] |
| ch_blank | input | 3 | Per-lane synchronous blanking flag, 1 mutes |
| msb_sel | output | 189 | True thermometer selects; lane c at [63c+62:63c] |
| msb_sel_n | output | 189 | Complementary thermometer selects |
| lsb_sel | output | 12 | True binary selects; lane c at [4c+3:4c] |
| lsb_sel_n | output | 12 | Complementary binary selects |

## Verification
The code and blanking results of a lane are due two edges of that lane's clock after the inputs are applied. The bench drives inputs while all three clocks are low. It then samples after two steps, comparing each cycle's outputs with the inputs from two steps earlier. Sleep and reset take effect without a clock, so they are checked one nanosecond after they change, before any clock edge. A lane whose clock is held still must keep its selects across several edges of the other lanes' clocks.

// File: rtl/dac_pkg.sv
package dac_pkg;
    localparam int DAC_NCH    = 3;
    localparam int DAC_CODE_W = 10;
    localparam int DAC_BIN_W  = 4;

    typedef enum logic {
        LANE_MUTE  = 1'b0,
        LANE_DRIVE = 1'b1
    } lane_state_e;
endpackage

// File: rtl/dac_therm_dec.sv
module dac_therm_dec #(
    parameter  int IN_W  = 6,
    localparam int OUT_W = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  bin_i,
    output logic [OUT_W-1:0] therm_o
);
    // Cell k is enabled when the segment value exceeds k.
    for (genvar k = 0; k < OUT_W; k++) begin : g_cell
        assign therm_o[k] = (int'(bin_i) > k);
    end
endmodule

// File: rtl/dac_lane.sv
module dac_lane
    import dac_pkg::*;
#(
    parameter  int CODE_W  = DAC_CODE_W,
    parameter  int BIN_W   = DAC_BIN_W,
    localparam int SEG_W   = CODE_W - BIN_W,
    localparam int THERM_W = (1 << SEG_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               blank_i,
    output logic [THERM_W-1:0] msb_o,
    output logic [THERM_W-1:0] msb_n_o,
    output logic [BIN_W-1:0]   lsb_o,
    output logic [BIN_W-1:0]   lsb_n_o
);
    logic [CODE_W-1:0]  code_q;
    logic               blank_q;
    logic [THERM_W-1:0] therm_d;
    logic [THERM_W-1:0] therm_q;
    logic [BIN_W-1:0]   bin_q;
    lane_state_e        state_q, state_d;
    logic               steer;

    // Input capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            blank_q <= 1'b1;
        end else begin
            code_q  <= code_i;
            blank_q <= blank_i;
        end
    end

    dac_therm_dec #(.IN_W(SEG_W)) u_dec (
        .bin_i  (code_q[CODE_W-1:BIN_W]),
        .therm_o(therm_d)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_MUTE:  state_d = blank_q ? LANE_MUTE : LANE_DRIVE;
            LANE_DRIVE: state_d = blank_q ? LANE_MUTE : LANE_DRIVE;
            default:    state_d = LANE_MUTE;
        endcase
    end

    // State and decoded-select register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_MUTE;
            therm_q <= '0;
            bin_q   <= '0;
        end else begin
            state_q <= state_d;
            therm_q <= therm_d;
            bin_q   <= code_q[BIN_W-1:0];
        end
    end

    // Output process: sleep gates asynchronously
    always_comb begin
        steer   = (state_q == LANE_DRIVE) && !sleep;
        msb_o   = steer ? therm_q  : '0;
        msb_n_o = steer ? ~therm_q : '0;
        lsb_o   = steer ? bin_q    : '0;
        lsb_n_o = steer ? ~bin_q   : '0;
    end
endmodule

// File: rtl/dac_front.sv
module dac_front
    import dac_pkg::*;
#(
    parameter  int NCH     = DAC_NCH,
    parameter  int CODE_W  = DAC_CODE_W,
    parameter  int BIN_W   = DAC_BIN_W,
    localparam int THERM_W = (1 << (CODE_W - BIN_W)) - 1
) (
    input  logic                   rst_n,
    input  logic                   sleep,
    input  logic [NCH-1:0]         ch_clk,
    input  logic [NCH*CODE_W-1:0]  ch_code,
    input  logic [NCH-1:0]         ch_blank,
    output logic [NCH*THERM_W-1:0] msb_sel,
    output logic [NCH*THERM_W-1:0] msb_sel_n,
    output logic [NCH*BIN_W-1:0]   lsb_sel,
    output logic [NCH*BIN_W-1:0]   lsb_sel_n
);
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        dac_lane #(.CODE_W(CODE_W), .BIN_W(BIN_W)) u_lane (
            .clk    (ch_clk[c]),
            .rst_n  (rst_n),
            .sleep  (sleep),
            .code_i (ch_code[c*CODE_W +: CODE_W]),
            .blank_i(ch_blank[c]),
            .msb_o  (msb_sel[c*THERM_W +: THERM_W]),
            .msb_n_o(msb_sel_n[c*THERM_W +: THERM_W]),
            .lsb_o  (lsb_sel[c*BIN_W +: BIN_W]),
            .lsb_n_o(lsb_sel_n[c*BIN_W +: BIN_W])
        );
    end
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
    parameter  int NCH     = 3,
    parameter  int CODE_W  = 10,
    parameter  int BIN_W   = 4,
    localparam int THERM_W = (1 << (CODE_W - BIN_W)) - 1
) (
    input logic                   rst_n,
    input logic                   sleep,
    input logic [NCH-1:0]         ch_clk,
    input logic [NCH*CODE_W-1:0]  ch_code,
    input logic [NCH-1:0]         ch_blank,
    input logic [NCH*THERM_W-1:0] msb_sel,
    input logic [NCH*THERM_W-1:0] msb_sel_n,
    input logic [NCH*BIN_W-1:0]   lsb_sel,
    input logic [NCH*BIN_W-1:0]   lsb_sel_n
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic [THERM_W-1:0] m, mn;
        logic [BIN_W-1:0]   l, ln;
        logic [CODE_W-1:0]  cd;
        logic               bl;
        logic [1:0]         age;

        assign m  = msb_sel[c*THERM_W +: THERM_W];
        assign mn = msb_sel_n[c*THERM_W +: THERM_W];
        assign l  = lsb_sel[c*BIN_W +: BIN_W];
        assign ln = lsb_sel_n[c*BIN_W +: BIN_W];
        assign cd = ch_code[c*CODE_W +: CODE_W];
        assign bl = ch_blank[c];

        always_ff @(posedge ch_clk[c] or negedge rst_n) begin
            if (!rst_n)          age <= 2'd0;
            else if (age != 2'd2) age <= age + 2'd1;
        end

        assert_therm_shape_R1: assert property (@(posedge ch_clk[c]) disable iff (!rst_n)
            ((m & (m + 1'b1)) == '0));

        // R2 and R4 are also covered: weighted value two edges later
        assert_weight_R3: assert property (@(posedge ch_clk[c]) disable iff (!rst_n)
            (age == 2'd2 && !sleep && !$past(bl, 2)) |->
            ((($countones(m) << BIN_W) + int'(l)) == int'($past(cd, 2))));

        assert_comp_R5: assert property (@(posedge ch_clk[c]) disable iff (!rst_n)
            ((m & mn) == '0) && ((l & ln) == '0) &&
            ((((m | mn) == '0) && ((l | ln) == '0)) || ((&(m | mn)) && (&(l | ln)))));

        assert_blank_mute_R6: assert property (@(posedge ch_clk[c]) disable iff (!rst_n)
            (age == 2'd2 && $past(bl, 2)) |->
            (m == '0 && mn == '0 && l == '0 && ln == '0));

        assert_sleep_off_R7: assert property (@(posedge ch_clk[c]) disable iff (!rst_n)
            sleep |-> (m == '0 && mn == '0 && l == '0 && ln == '0));
    end
endmodule

bind dac_front dac_front_chk #(.NCH(NCH), .CODE_W(CODE_W), .BIN_W(BIN_W)) u_chk (.*);

// File: tb/dac_front_tb.sv
`timescale 1ns/1ps
module dac_front_tb;
    localparam int NCH = 3;
    localparam int CW  = 10;
    localparam int BW  = 4;
    localparam int TW  = 63;
    localparam int NRND = 300;

    logic            rst_n = 1'b1;
    logic            sleep = 1'b0;
    logic [NCH-1:0]  ck = '0;
    logic [NCH-1:0]  run = '1;
    logic [NCH-1:0]  ch_clk;
    logic [NCH*CW-1:0] ch_code = '0;
    logic [NCH-1:0]  ch_blank = '0;
    logic [NCH*TW-1:0] msb_sel, msb_sel_n;
    logic [NCH*BW-1:0] lsb_sel, lsb_sel_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [CW-1:0] hc [NCH][NRND];
    logic          hb [NCH][NRND];

    assign ch_clk = ck & run;

    // 100 MHz lane clocks, staggered by 1 ns
    initial forever #5 ck[0] = ~ck[0];
    initial begin #1; forever #5 ck[1] = ~ck[1]; end
    initial begin #2; forever #5 ck[2] = ~ck[2]; end

    dac_front u_dut (
        .rst_n(rst_n), .sleep(sleep), .ch_clk(ch_clk), .ch_code(ch_code),
        .ch_blank(ch_blank), .msb_sel(msb_sel), .msb_sel_n(msb_sel_n),
        .lsb_sel(lsb_sel), .lsb_sel_n(lsb_sel_n)
    );

    function automatic logic [TW-1:0] exp_therm(logic [CW-1:0] cd);
        logic [TW-1:0] r = '0;
        for (int i = 0; i < TW; i++) r[i] = (i < int'(cd[CW-1:BW]));
        return r;
    endfunction

    // Step to 8 ns after a ck[0] rise: every lane clock is low there
    task automatic step();
        @(posedge ck[0]);
        #8;
    endtask

    task automatic chk(int c, logic [CW-1:0] cd, logic mute, string tag);
        logic [TW-1:0] m, mn, em, emn;
        logic [BW-1:0] l, ln, el, eln;
        m  = msb_sel[c*TW +: TW];   mn = msb_sel_n[c*TW +: TW];
        l  = lsb_sel[c*BW +: BW];   ln = lsb_sel_n[c*BW +: BW];
        em  = mute ? '0 : exp_therm(cd);
        emn = mute ? '0 : ~exp_therm(cd);
        el  = mute ? '0 : cd[BW-1:0];
        eln = mute ? '0 : ~cd[BW-1:0];
        n_tests++;
        if (m !== em || mn !== emn || l !== el || ln !== eln) begin
            n_fail++;
            $display("FAIL %s lane%0d msb=%h msb_n=%h lsb=%h lsb_n=%h exp msb=%h msb_n=%h lsb=%h lsb_n=%h",
                     tag, c, m, mn, l, ln, em, emn, el, eln);
        end
    endtask

    task automatic chk_sum(int c, logic [CW-1:0] cd, string tag);
        int got;
        got = $countones(msb_sel[c*TW +: TW]) * 16 + int'(lsb_sel[c*BW +: BW]);
        n_tests++;
        if (got != int'(cd)) begin
            n_fail++;
            $display("FAIL %s lane%0d weighted=%0d exp=%0d", tag, c, got, cd);
        end
    endtask

    task automatic drive_all(logic [CW-1:0] cd, logic bl);
        for (int c = 0; c < NCH; c++) begin
            ch_code[c*CW +: CW] = cd ^ CW'(c * 3);
            ch_blank[c] = bl;
        end
    endtask

    task automatic directed(logic [CW-1:0] cd, string tag);
        drive_all(cd, 1'b0);
        step(); step();
        for (int c = 0; c < NCH; c++) begin
            chk(c, cd ^ CW'(c * 3), 1'b0, tag);
            chk_sum(c, cd ^ CW'(c * 3), "R3");
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        #1 rst_n = 1'b0;
        step(); step();
        for (int c = 0; c < NCH; c++) chk(c, '0, 1'b1, "R8");
        step();
        rst_n = 1'b1;
        step();
        // R8: one edge after release, still mute
        for (int c = 0; c < NCH; c++) chk(c, '0, 1'b1, "R8");

        // R3 corner codes: full, half, zero
        directed(10'd1023, "R3");
        directed(10'd512,  "R3");
        directed(10'd0,    "R3");
        // R1 segment boundaries, R2 binary field
        directed(10'd15,   "R1");
        directed(10'd16,   "R1");
        directed(10'd1008, "R1");
        directed(10'd5,    "R2");
        directed(10'd10,   "R2");

        // R5 complement and R6 blanking under random patterns (R4 latency)
        for (int n = 0; n < NRND; n++) begin
            for (int c = 0; c < NCH; c++) begin
                hc[c][n] = CW'($urandom);
                hb[c][n] = ($urandom_range(7) == 0);
                ch_code[c*CW +: CW] = hc[c][n];
                ch_blank[c] = hb[c][n];
            end
            step();
            if (n >= 1)
                for (int c = 0; c < NCH; c++)
                    chk(c, hc[c][n-1], hb[c][n-1], hb[c][n-1] ? "R6" : "R4");
        end

        // R6: blank then resume
        drive_all(10'd700, 1'b1);
        step(); step();
        for (int c = 0; c < NCH; c++) chk(c, '0, 1'b1, "R6");
        drive_all(10'd700, 1'b0);
        step();
        for (int c = 0; c < NCH; c++) chk(c, '0, 1'b1, "R6");
        step();
        for (int c = 0; c < NCH; c++) chk(c, 10'd700 ^ CW'(c * 3), 1'b0, "R6");

        // R7: sleep acts without a clock, and release restores
        #1 sleep = 1'b1;
        #0.5;
        for (int c = 0; c < NCH; c++) chk(c, '0, 1'b1, "R7");
        #0.2 sleep = 1'b0;
        #0.2;
        for (int c = 0; c < NCH; c++) chk(c, 10'd700 ^ CW'(c * 3), 1'b0, "R7");
        step();
        sleep = 1'b1;
        drive_all(10'd333, 1'b0);
        step(); step();
        for (int c = 0; c < NCH; c++) chk(c, '0, 1'b1, "R7");
        sleep = 1'b0;
        #1;
        for (int c = 0; c < NCH; c++) chk(c, 10'd333 ^ CW'(c * 3), 1'b0, "R7");

        // R4: stop the blue clock; its selects must hold
        step();
        run[2] = 1'b0;
        drive_all(10'd900, 1'b0);
        step(); step(); step();
        chk(0, 10'd900, 1'b0, "R4");
        chk(1, 10'd900 ^ 10'd3, 1'b0, "R4");
        chk(2, 10'd333 ^ 10'd6, 1'b0, "R4");
        run[2] = 1'b1;
        step(); step();
        chk(2, 10'd900 ^ 10'd6, 1'b0, "R4");

        // R8: reset mid-run clears at once
        rst_n = 1'b0;
        #1;
        for (int c = 0; c < NCH; c++) chk(c, '0, 1'b1, "R8");
        step();
        rst_n = 1'b1;
        step(); step();
        for (int c = 0; c < NCH; c++) chk(c, 10'd900 ^ CW'(c * 3), 1'b0, "R8");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule